// File: doc/BRIEF.md
# Capture/Compare Timer with Infrared Carrier Gating

The block is a 16-bit up-counting timer with five channels. Each channel works either as a compare output or as an edge capture input. As a compare output it produces a pulse-width signal from the running count. As a capture input it records the count when a selected edge arrives. The count advances once per prescaled clock tick and wraps after a programmable period. Each wrap sets an overflow flag.

An 8-bit carrier timer sits beside the main timer. It has its own prescaler, period and compare value, and it produces a carrier waveform. In infrared mode the main counter advances once per completed carrier period instead of once per prescaled tick. Every compare output is then ANDed with the carrier, so a single configuration yields a modulated infrared burst pattern. Software reaches all state through a single-cycle write port and a combinational read port that share one address.

Register addresses:
- 0: main control. Bit 0 enables the counter, bits 2:1 select the prescaler, bit 3 selects infrared mode.
- 1: main period.
- 2: carrier control. Bit 0 enables the carrier, bits 2:1 select its prescaler.
- 3: carrier period.
- 4: carrier compare.
- 5: flags. Bit 0 is overflow, bit 1+k is the capture flag of channel k. Writing a 1 to a bit clears it.
- 6: main count (read only).
- 7: carrier count (read only).
- 8+k: configuration of channel k.
- 16+k: compare/capture value of channel k.

Top module: `ir_timer`

## Requirements
- R1: After reset the main count is 0, the main period reads 0xFFFF, all flags read 0, and all channel outputs and the carrier output are low.
- R2: While the main timer is enabled and not in infrared mode, it advances once every 1, 8, 32 or 128 clocks. Main control bits 2:1 select the divider: 00 gives 1, 01 gives 8, 10 gives 32 and 11 gives 128.
- R3: The main count steps by one from 0 up to the period value and then returns to 0. It never exceeds the period. A write to the period register clears the count.
- R4: A wrap of the main count sets flags bit 0. The flag stays set until software writes a 1 to that bit.
- R5: A channel whose configuration bit 0 is 0 is in compare mode. Its output is high exactly while the main count is below its 16-bit value.
- R6: A channel whose configuration bit 0 is 1 is in capture mode. Configuration bits 2:1 select the edge: 01 is rising, 10 is falling, 11 is both. The input passes through a two-flop synchronizer. On a selected edge the channel stores the main count in its value register and sets flags bit 1+k.
- R7: A capture edge that is not selected (including any edge when bits 2:1 are 00) leaves the flag and the value register unchanged.
- R8: The carrier count steps from 0 to the carrier period and then returns to 0. The carrier output is high exactly while the carrier count is below the carrier compare value.
- R9: In infrared mode the main count advances exactly once per completed carrier period.
- R10: In infrared mode every compare output equals its compare result ANDed with the carrier output.
- R11: A channel in capture mode drives its output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the register at addr_i |
| addr_i | input | 5 | Register address for both write and read |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Combinational read data of the register at addr_i |
| cap_i | input | 5 | Capture inputs, one per channel, asynchronous |
| ch_o | output | 5 | Channel outputs |
| carrier_o | output | 1 | Carrier waveform |

## Verification
A register write takes effect at the clock edge on which it is sampled. The count and the outputs are combinational functions of registered state, so the bench samples the count, the channel outputs and the carrier on the falling edge, within the same cycle. Capture results appear on the third rising edge after an input change, because of the two synchronizer flops and the edge flop. The bench therefore waits five cycles after each input change before it reads the flags and the value registers. Prescaler and infrared stepping are measured as the spacing between successive count changes, and the first, partial interval is ignored.

// File: rtl/ir_timer_pkg.sv
package ir_timer_pkg;
  localparam int PRE_W = 7;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int A_M_CTRL   = 0;
  localparam int A_M_PERIOD = 1;
  localparam int A_C_CTRL   = 2;
  localparam int A_C_PERIOD = 3;
  localparam int A_C_CMP    = 4;
  localparam int A_FLAGS    = 5;
  localparam int A_M_CNT    = 6;
  localparam int A_C_CNT    = 7;
  localparam int A_CH_CFG   = 8;
  localparam int A_CH_VAL   = 16;

  // terminal count of the prescaler: divide by 1, 8, 32, 128
  function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] sel);
    case (sel)
      2'b00:   return PRE_W'(0);
      2'b01:   return PRE_W'(7);
      2'b10:   return PRE_W'(31);
      default: return PRE_W'(127);
    endcase
  endfunction
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen import ir_timer_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] lim;

  assign lim    = pre_limit(sel_i);
  assign tick_o = en_i && (div_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (!en_i)   div_q <= '0;
    else if (tick_o)  div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/ir_up_counter.sv
module ir_up_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  assign wrap_o = step_i && (cnt_o == period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (clr_i)   cnt_o <= '0;
    else if (wrap_o)  cnt_o <= '0;
    else if (step_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ir_carrier.sv
module ir_carrier #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [1:0]   sel_i,
  input  logic         clr_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] cmp_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o,
  output logic         pwm_o
);
  logic tick;

  ir_tick_gen u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .sel_i (sel_i),
    .tick_o(tick)
  );

  ir_up_counter #(.W(W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .step_i  (tick),
    .period_i(period_i),
    .cnt_o   (cnt_o),
    .wrap_o  (wrap_o)
  );

  assign pwm_o = cnt_o < cmp_i;
endmodule

// File: rtl/ir_cc_channel.sv
module ir_cc_channel import ir_timer_pkg::*; #(
  parameter int W = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic [W-1:0] cnt_i,
  input  logic      cap_mode_i,
  input  edge_sel_e edge_i,
  input  logic      we_i,
  input  logic [W-1:0] wdata_i,
  input  logic      cap_i,
  output logic [W-1:0] val_o,
  output logic      pwm_o,
  output logic      cap_evt_o
);
  logic [2:0] sync_q;
  logic rise, fall, take_rise, take_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], cap_i};
  end

  assign rise      = sync_q[1] & ~sync_q[2];
  assign fall      = ~sync_q[1] & sync_q[2];
  assign take_rise = (edge_i == EDGE_RISE) || (edge_i == EDGE_BOTH);
  assign take_fall = (edge_i == EDGE_FALL) || (edge_i == EDGE_BOTH);
  assign cap_evt_o = cap_mode_i && ((take_rise && rise) || (take_fall && fall));

  // capture has priority over a software write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        val_o <= '0;
    else if (cap_evt_o) val_o <= cnt_i;
    else if (we_i)      val_o <= wdata_i;
  end

  assign pwm_o = !cap_mode_i && (cnt_i < val_o);
endmodule

// File: rtl/ir_timer.sv
module ir_timer import ir_timer_pkg::*; #(
  parameter int CNT_W  = 16,
  parameter int CAR_W  = 8,
  parameter int N_CH   = 5,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic [N_CH-1:0]   cap_i,
  output logic [N_CH-1:0]   ch_o,
  output logic              carrier_o
);
  localparam int CFG_W = 3;

  logic [3:0]       m_ctrl_q;
  logic [CNT_W-1:0] m_period_q;
  logic [2:0]       c_ctrl_q;
  logic [CAR_W-1:0] c_period_q, c_cmp_q;
  logic [CFG_W-1:0] cfg_q [N_CH];
  logic [N_CH:0]    flags_q, flag_set, flag_clr;

  logic m_en, ir_mode, m_tick, m_step, m_clr, m_wrap;
  logic c_clr, c_wrap, c_pwm;
  logic [CNT_W-1:0] m_cnt;
  logic [CAR_W-1:0] c_cnt;
  logic [CNT_W-1:0] ch_val [N_CH];
  logic [N_CH-1:0]  pwm, cap_evt, cap_mode;

  assign m_en    = m_ctrl_q[0];
  assign ir_mode = m_ctrl_q[3];
  assign m_clr   = we_i && (addr_i == ADDR_W'(A_M_PERIOD));
  assign c_clr   = we_i && (addr_i == ADDR_W'(A_C_PERIOD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctrl_q   <= '0;
      m_period_q <= '1;
      c_ctrl_q   <= '0;
      c_period_q <= '1;
      c_cmp_q    <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_W'(A_M_CTRL):   m_ctrl_q   <= wdata_i[3:0];
        ADDR_W'(A_M_PERIOD): m_period_q <= wdata_i;
        ADDR_W'(A_C_CTRL):   c_ctrl_q   <= wdata_i[2:0];
        ADDR_W'(A_C_PERIOD): c_period_q <= wdata_i[CAR_W-1:0];
        ADDR_W'(A_C_CMP):    c_cmp_q    <= wdata_i[CAR_W-1:0];
        default: ;
      endcase
    end
  end

  ir_tick_gen u_m_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (m_en),
    .sel_i (m_ctrl_q[2:1]),
    .tick_o(m_tick)
  );

  ir_carrier #(.W(CAR_W)) u_carrier (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (c_ctrl_q[0]),
    .sel_i   (c_ctrl_q[2:1]),
    .clr_i   (c_clr),
    .period_i(c_period_q),
    .cmp_i   (c_cmp_q),
    .cnt_o   (c_cnt),
    .wrap_o  (c_wrap),
    .pwm_o   (c_pwm)
  );

  // infrared mode: one main step per completed carrier period
  assign m_step = m_en && (ir_mode ? c_wrap : m_tick);

  ir_up_counter #(.W(CNT_W)) u_m_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (m_clr),
    .step_i  (m_step),
    .period_i(m_period_q),
    .cnt_o   (m_cnt),
    .wrap_o  (m_wrap)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[k] <= '0;
      else if (we_i && addr_i == ADDR_W'(A_CH_CFG + k)) cfg_q[k] <= wdata_i[CFG_W-1:0];
    end

    assign cap_mode[k] = cfg_q[k][0];

    ir_cc_channel #(.W(CNT_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cnt_i     (m_cnt),
      .cap_mode_i(cap_mode[k]),
      .edge_i    (edge_sel_e'(cfg_q[k][2:1])),
      .we_i      (we_i && addr_i == ADDR_W'(A_CH_VAL + k)),
      .wdata_i   (wdata_i),
      .cap_i     (cap_i[k]),
      .val_o     (ch_val[k]),
      .pwm_o     (pwm[k]),
      .cap_evt_o (cap_evt[k])
    );

    assign ch_o[k] = pwm[k] & (~ir_mode | c_pwm);
  end

  assign carrier_o = c_pwm;
  assign flag_set  = {cap_evt, m_wrap};
  assign flag_clr  = (we_i && addr_i == ADDR_W'(A_FLAGS)) ? wdata_i[N_CH:0] : '0;

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~flag_clr) | flag_set;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(A_M_CTRL):   rdata_o[3:0]       = m_ctrl_q;
      ADDR_W'(A_M_PERIOD): rdata_o            = m_period_q;
      ADDR_W'(A_C_CTRL):   rdata_o[2:0]       = c_ctrl_q;
      ADDR_W'(A_C_PERIOD): rdata_o[CAR_W-1:0] = c_period_q;
      ADDR_W'(A_C_CMP):    rdata_o[CAR_W-1:0] = c_cmp_q;
      ADDR_W'(A_FLAGS):    rdata_o[N_CH:0]    = flags_q;
      ADDR_W'(A_M_CNT):    rdata_o            = m_cnt;
      ADDR_W'(A_C_CNT):    rdata_o[CAR_W-1:0] = c_cnt;
      default: ;
    endcase
    for (int k = 0; k < N_CH; k++) begin
      if (addr_i == ADDR_W'(A_CH_CFG + k)) rdata_o[CFG_W-1:0] = cfg_q[k];
      if (addr_i == ADDR_W'(A_CH_VAL + k)) rdata_o = ch_val[k];
    end
  end
endmodule

// File: rtl/ir_timer_chk.sv
module ir_timer_chk #(
  parameter int W    = 16,
  parameter int N_CH = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [W-1:0]    cnt_i,
  input logic [W-1:0]    period_i,
  input logic            step_i,
  input logic            clr_i,
  input logic            wrap_i,
  input logic            ovf_i,
  input logic            ir_i,
  input logic            c_wrap_i,
  input logic            carrier_i,
  input logic [N_CH-1:0] cap_mode_i,
  input logic [N_CH-1:0] ch_i
);
  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && cnt_i != period_i) |=> cnt_i == $past(cnt_i) + 1'b1);

  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cnt_i == period_i) |=> cnt_i == '0);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> $stable(cnt_i));

  assert_ovf_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> ovf_i);

  assert_ir_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_i && !c_wrap_i && !clr_i) |=> $stable(cnt_i));

  assert_ir_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_i && !carrier_i) |-> ch_i == '0);

  assert_cap_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_i & cap_mode_i) == '0);
endmodule

bind ir_timer ir_timer_chk #(.W(CNT_W), .N_CH(N_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt_i     (m_cnt),
  .period_i  (m_period_q),
  .step_i    (m_step),
  .clr_i     (m_clr),
  .wrap_i    (m_wrap),
  .ovf_i     (flags_q[0]),
  .ir_i      (ir_mode),
  .c_wrap_i  (c_wrap),
  .carrier_i (carrier_o),
  .cap_mode_i(cap_mode),
  .ch_i      (ch_o)
);

// File: tb/test_ir_timer.sv
module test_ir_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [4:0]  cap = '0;
  logic [4:0]  ch;
  logic        car;
  int total = 0;
  int bad = 0;
  bit done = 0;

  ir_timer i_ir_timer (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cap_i(cap), .ch_o(ch), .carrier_o(car)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    we = 1'b1; addr = 5'(a); wdata = 16'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    addr = 5'(a);
    #1 d = int'(rdata);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, cur, prev, f, vcap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6, v);  chk(v == 0, "R1 count", v, 0);
    rd(1, v);  chk(v == 16'hFFFF, "R1 period", v, 16'hFFFF);
    rd(5, v);  chk(v == 0, "R1 flags", v, 0);
    chk(ch == 0, "R1 ch_o", int'(ch), 0);
    chk(car == 0, "R1 carrier_o", int'(car), 0);

    // R3 R4 R5 compare sweep
    for (int p = 2; p <= 5; p += 3) begin
      for (int c = 0; c <= p + 1; c++) begin
        wr(0, 0); wr(1, p); wr(16, c); wr(5, 16'hFFFF); wr(0, 1);
        addr = 5'd6;
        prev = -1;
        for (int i = 0; i < 2 * (p + 1) + 2; i++) begin
          @(negedge clk);
          cur = int'(rdata);
          chk(ch[0] == (cur < c), "R5 pwm", int'(ch[0]), int'(cur < c));
          chk(ch[4:1] == 0, "R5 pwm zero compare", int'(ch[4:1]), 0);
          if (prev >= 0) chk(cur == ((prev == p) ? 0 : prev + 1), "R3 sequence", cur,
                             (prev == p) ? 0 : prev + 1);
          prev = cur;
        end
        wr(0, 0);
        rd(5, v); chk(v[0] == 1, "R4 overflow set", v & 1, 1);
        wr(5, 1);
        rd(5, v); chk(v[0] == 0, "R4 overflow cleared", v & 1, 0);
      end
    end

    // R2 prescaler
    for (int s = 0; s < 4; s++) begin
      int dv, last, nchg;
      dv = (s == 0) ? 1 : (s == 1) ? 8 : (s == 2) ? 32 : 128;
      wr(0, 0); wr(1, 16'hFFFF); wr(0, (s << 1) | 1);
      rd(6, prev);
      last = -1; nchg = 0;
      for (int i = 0; i < dv * 5 + 2; i++) begin
        @(negedge clk);
        cur = int'(rdata);
        if (cur != prev) begin
          chk(cur == prev + 1, "R3 step", cur, prev + 1);
          if (last >= 0) chk(i - last == dv, "R2 divider", i - last, dv);
          last = i; nchg++;
        end
        prev = cur;
      end
      chk(nchg >= 4, "R2 step count", nchg, 4);
    end

    // R8 R9 R10 infrared mode
    wr(0, 0); wr(2, 0); wr(3, 4); wr(4, 2); wr(1, 3); wr(16, 2);
    wr(2, 1); wr(0, 9);
    addr = 5'd7;
    prev = -1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      cur = int'(rdata);
      chk(car == (cur < 2), "R8 carrier", int'(car), int'(cur < 2));
      if (prev >= 0) chk(cur == ((prev == 4) ? 0 : prev + 1), "R8 sequence", cur,
                         (prev == 4) ? 0 : prev + 1);
      prev = cur;
    end
    begin
      int last;
      addr = 5'd6;
      #1 prev = int'(rdata);
      last = -1;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        cur = int'(rdata);
        chk(ch[0] == ((cur < 2) && car), "R10 gated", int'(ch[0]), int'((cur < 2) && car));
        if (cur != prev) begin
          if (last >= 0) chk(i - last == 5, "R9 carrier step", i - last, 5);
          last = i;
        end
        prev = cur;
      end
    end
    wr(0, 0); wr(2, 0);

    // R6 R7 R11 capture sweep
    wr(1, 16'hFFFF); wr(0, 1);
    repeat (37) @(negedge clk);
    wr(0, 0);
    rd(6, vcap);
    chk(vcap != 0, "R6 frozen count", vcap, 1);
    for (int k = 0; k < 5; k++) begin
      for (int e = 0; e < 4; e++) begin
        for (int lvl = 1; lvl >= 0; lvl--) begin
          bit exp_hit;
          exp_hit = (lvl == 1) ? (e == 1 || e == 3) : (e == 2 || e == 3);
          wr(16 + k, 16'hAAAA); wr(8 + k, (e << 1) | 1); wr(5, 16'hFFFF);
          cap[k] = lvl[0];
          repeat (5) @(negedge clk);
          chk(ch[k] == 0, "R11 capture output low", int'(ch[k]), 0);
          rd(5, f);
          chk(f[k + 1] == exp_hit, exp_hit ? "R6 flag" : "R7 flag", int'(f[k + 1]), int'(exp_hit));
          rd(16 + k, v);
          chk(v == (exp_hit ? vcap : 16'hAAAA), exp_hit ? "R6 value" : "R7 value", v,
              exp_hit ? vcap : 16'hAAAA);
        end
        wr(8 + k, 0);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule